// File: doc/BRIEF.md
# Conditional Slot Status Counter Bank

This block keeps four event counters for a two-channel, time-triggered bus controller. Each counter has its own condition register. At the end of every slot, the receive status of both channels arrives: frame indicators and error flags. Each counter checks that status against its condition and adds 0, 1 or 2. A cycle-end strobe then does one of two things for each counter. Either it publishes the count for the cycle that just finished and starts again from zero, or the counter keeps accumulating.

The host reaches the four condition registers through one 16-bit control word. The two low bits select a register and a write-mode bit decides what a write changes. In full mode a write stores every condition field into the register it selects. In select-only mode a write moves only the selector, so the host can read any register back without disturbing it. The counter values are presented side by side on one wide output.

Top module: `slot_status_counter_bank`

## Requirements
- R1: Control word layout: bits [1:0] selector, bit 2 write mode, bit 3 multi-cycle, bits [5:4] channel mode, bit 6 valid-only, bit 7 sync-only, bit 8 non-null-only, bit 9 startup-only, bits [13:10] error mask (bit 13 syntax, 12 content, 11 boundary, 10 conflict). A write with bit 2 = 0 stores bits [13:3] into the register that the written selector picks, and also updates the selector and write mode.
- R2: A write with bit 2 = 1 changes only the selector and the write-mode bit. None of the four condition registers changes, whatever the other bits hold.
- R3: Reading the control word returns the selected register's fields in the R1 layout, together with the current selector and write mode. Bits [15:14] always read 0.
- R4: Each qualifier bit that is set removes a channel's slot from counting unless that channel meets it. valid-only needs frame bit 0 (valid) = 1. sync-only needs frame bit 1 (sync) = 1. non-null-only needs frame bit 2 (null) = 0. startup-only needs frame bit 3 (startup) = 1.
- R5: A nonzero error mask counts a channel only if at least one masked error flag is set. The error flag bit order matches the mask: 3 syntax, 2 content, 1 boundary, 0 conflict. A zero mask places no demand on the error flags.
- R6: Channel mode 00 adds 1 when channel A matches. Mode 01 adds 1 when channel B matches. Mode 10 adds 1 when either channel matches.
- R7: Channel mode 11 adds 2 when both channels match and adds 1 when only one channel matches.
- R8: With multi-cycle = 0, the readable count changes only on the cycle-end strobe. It then shows the count of the cycle that just closed, including a slot that ends in the same clock, and the running count restarts at 0.
- R9: With multi-cycle = 1, the readable count tracks the running count, and the cycle-end strobe has no effect on it.
- R10: A counter saturates at its all-ones value (0xFFFF) and never wraps.
- R11: Synchronous active-low reset clears the selector, the write mode, all condition registers, all running counts and all published counts.
- R12: Counter n, at bits [16n+15:16n] of the count output, uses only condition register n. Writing one register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Control word write strobe |
| host_wdata | input | 16 | Control word write data |
| host_rdata | output | 16 | Control word read data |
| slot_done | input | 1 | Slot-end strobe qualifying the channel status |
| a_frame | input | 4 | Channel A frame indicators: [0] valid, [1] sync, [2] null, [3] startup |
| a_err | input | 4 | Channel A error flags: [3] syntax, [2] content, [1] boundary, [0] conflict |
| b_frame | input | 4 | Channel B frame indicators, same order as a_frame |
| b_err | input | 4 | Channel B error flags, same order as a_err |
| cycle_end | input | 1 | Communication cycle-end strobe |
| counts | output | 64 | Four readable counts, counter n at bits [16n+15:16n] |

## Verification
Three slots are sent with status on channel A only, on channel B only, and on both channels. Together they separate the four channel modes, and they show the 1-or-2 step of the summing mode. Next comes a series of frames, each of which fails exactly one qualifier. Error flag patterns that lie inside and outside the mask then show that each qualifier and each mask bit works alone. Cycle-end strobes are applied both alone and in the same clock as a slot, which separates publish-and-clear from accumulation and shows that the coincident slot lands in the closing cycle. A long stream of double increments drives one counter across its saturation point.

// File: rtl/slot_cnt_pkg.sv
// Package: shared constants and types for the conditional slot status counter bank.
// Assumes a 2-bit selector, so there are four counters; the control word field
// positions are fixed by the host register layout.
package slot_cnt_pkg;

    localparam int SEL_W     = 2;
    localparam int NUM_CNT   = 1 << SEL_W;
    localparam int WORD_W    = 16;
    localparam int NUM_CH    = 2;
    localparam int POS_WMODE = 2;
    localparam int POS_MULTI = 3;
    localparam int POS_MASK  = 10;
    localparam int CFG_W     = POS_MASK + 4 - POS_MULTI;

    typedef enum logic [1:0] {
        MODE_A   = 2'b00,
        MODE_B   = 2'b01,
        MODE_ANY = 2'b10,
        MODE_SUM = 2'b11
    } chan_mode_e;

    // Packed so that the member order matches control word bits [13:3].
    typedef struct packed {
        logic [3:0] err_mask;
        logic       need_startup;
        logic       need_nonnull;
        logic       need_sync;
        logic       need_valid;
        chan_mode_e mode;
        logic       multi;
    } cond_cfg_t;

    typedef struct packed {
        logic startup;
        logic is_null;
        logic sync;
        logic valid;
    } frame_ind_t;

endpackage

// File: rtl/cond_regs.sv
// Module: cond_regs
// Holds the four condition registers, the selector and the write mode. The host
// reaches them through one control word. A write with the write-mode bit clear
// loads the selected register; with it set, only the selector moves.
// Assumes one write per clock at most; the read data are combinational.
module cond_regs
    import slot_cnt_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [WORD_W-1:0]           wdata_i,
    output logic [WORD_W-1:0]           rdata_o,
    output cond_cfg_t [NUM_CNT-1:0]     cfg_o
);

    logic [SEL_W-1:0]          sel_q;
    logic                      wmode_q;
    cond_cfg_t [NUM_CNT-1:0]   cfg_q;
    logic [SEL_W-1:0]          wsel;
    logic                      wmode_new;

    assign wsel      = wdata_i[SEL_W-1:0];
    assign wmode_new = wdata_i[POS_WMODE];

    // Purpose: register host writes to the selector, write mode and condition fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            wmode_q <= 1'b0;
            cfg_q   <= '0;
        end else if (wr_en_i) begin
            sel_q   <= wsel;
            wmode_q <= wmode_new;
            if (!wmode_new) begin
                cfg_q[wsel] <= cond_cfg_t'(wdata_i[POS_MASK+3:POS_MULTI]);
            end
        end
    end

    // Purpose: assemble the read view of the selected register.
    always_comb begin
        rdata_o = {2'b00, cfg_q[sel_q], wmode_q, sel_q};
    end

    assign cfg_o = cfg_q;

    // R1: a full-mode write is visible in the read word on the next clock
    assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wdata_i[POS_WMODE]) |=> rdata_o == {2'b00, $past(wdata_i[13:0])});

    // R2: a select-only write leaves every condition register unchanged
    assert_sel_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i[POS_WMODE]) |=> $stable(cfg_o));

    // R3: reserved bits written as ones still read back as zero
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i[WORD_W-1:WORD_W-2] != 2'b00) |=> rdata_o[WORD_W-1:WORD_W-2] == 2'b00);

endmodule

// File: rtl/slot_match.sv
// Module: slot_match
// Evaluates one condition register against the status of both channels and
// produces the increment (0, 1 or 2) that follows from the channel mode.
// Assumes the status inputs are meaningful only when the caller's slot strobe is high.
module slot_match
    import slot_cnt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  cond_cfg_t                  cfg_i,
    input  frame_ind_t [NUM_CH-1:0]    ind_i,
    input  logic [NUM_CH-1:0][3:0]     err_i,
    output logic [1:0]                 inc_o
);

    logic [NUM_CH-1:0] hit;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic qual_ok;
        logic err_ok;

        // Purpose: decide whether this channel meets the qualifiers and error mask.
        always_comb begin
            qual_ok = (!cfg_i.need_valid   ||  ind_i[ch].valid)
                   && (!cfg_i.need_sync    ||  ind_i[ch].sync)
                   && (!cfg_i.need_nonnull || !ind_i[ch].is_null)
                   && (!cfg_i.need_startup ||  ind_i[ch].startup);
            err_ok  = (cfg_i.err_mask == 4'b0000) || (|(cfg_i.err_mask & err_i[ch]));
        end

        assign hit[ch] = qual_ok && err_ok;
    end

    // Purpose: combine the per-channel results according to the channel mode.
    always_comb begin
        case (cfg_i.mode)
            MODE_A:   inc_o = {1'b0, hit[0]};
            MODE_B:   inc_o = {1'b0, hit[1]};
            MODE_ANY: inc_o = {1'b0, |hit};
            default:  inc_o = {1'b0, hit[0]} + {1'b0, hit[1]};
        endcase
    end

    // R6: only the summing mode may step by two
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.mode != MODE_SUM) |-> (inc_o != 2'd2));

    // R4: valid-only with no valid frame on either channel never counts
    assert_valid_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.need_valid && !ind_i[0].valid && !ind_i[1].valid) |-> (inc_o == 2'd0));

endmodule

// File: rtl/event_counter.sv
// Module: event_counter
// One saturating counter. It keeps a running count and a published count. In
// single-cycle mode the cycle-end strobe copies the running count, including a
// coincident slot, to the published count and clears the running count. In
// multi-cycle mode the readable value is the running count itself.
// Assumes inc_i is valid only while slot_i is high.
module event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_i,
    input  logic [1:0]       inc_i,
    input  logic             cycle_end_i,
    input  logic             multi_i,
    output logic [CNT_W-1:0] value_o
);

    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] step;
    logic             clear;

    // Purpose: compute the saturated next running count for this slot.
    always_comb begin
        sum   = {1'b0, run_q} + {{(CNT_W-1){1'b0}}, inc_i};
        if (!slot_i)          step = run_q;
        else if (sum[CNT_W])  step = MAX_VAL;
        else                  step = sum[CNT_W-1:0];
        clear = cycle_end_i && !multi_i;
    end

    // Purpose: advance the running count and publish it at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            snap_q <= '0;
        end else if (clear) begin
            snap_q <= step;
            run_q  <= '0;
        end else begin
            run_q  <= step;
        end
    end

    assign value_o = multi_i ? run_q : snap_q;

    // R10: once saturated, the count stays at its maximum until cleared
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == MAX_VAL && !clear) |=> run_q == MAX_VAL);

    // R8: single-cycle cycle end restarts the running count at zero
    assert_cycle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> run_q == '0);

    // R9: without a slot or a clear the running count holds
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_i && !clear) |=> $stable(run_q));

endmodule

// File: rtl/slot_status_counter_bank.sv
// Module: slot_status_counter_bank (top)
// Four condition registers behind one control word, each governing its own
// saturating slot status counter. One match unit and one counter are generated
// per condition register.
// Assumes slot_done and cycle_end are single-clock strobes from the protocol engine.
module slot_status_counter_bank
    import slot_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [15:0]              host_wdata,
    output logic [15:0]              host_rdata,
    input  logic                     slot_done,
    input  logic [3:0]               a_frame,
    input  logic [3:0]               a_err,
    input  logic [3:0]               b_frame,
    input  logic [3:0]               b_err,
    input  logic                     cycle_end,
    output logic [4*CNT_W-1:0]       counts
);

    cond_cfg_t [NUM_CNT-1:0]  cfg;
    frame_ind_t [NUM_CH-1:0]  ind;
    logic [NUM_CH-1:0][3:0]   err;

    assign ind[0] = frame_ind_t'(a_frame);
    assign ind[1] = frame_ind_t'(b_frame);
    assign err[0] = a_err;
    assign err[1] = b_err;

    cond_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (host_wr),
        .wdata_i (host_wdata),
        .rdata_o (host_rdata),
        .cfg_o   (cfg)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic [1:0] inc;

        slot_match u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[n]),
            .ind_i (ind),
            .err_i (err),
            .inc_o (inc)
        );

        event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .slot_i      (slot_done),
            .inc_i       (inc),
            .cycle_end_i (cycle_end),
            .multi_i     (cfg[n].multi),
            .value_o     (counts[n*CNT_W +: CNT_W])
        );
    end

endmodule

// File: tb/slot_status_counter_bank_test.sv
`timescale 1ns/1ps
module slot_status_counter_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        slot_done = 1'b0;
    logic [3:0]  a_frame = '0, a_err = '0, b_frame = '0, b_err = '0;
    logic        cycle_end = 1'b0;
    logic [63:0] counts;

    int n_checks = 0;
    int n_errs   = 0;

    int m_sel = 0, m_wm = 0;
    int m_cfg [4];
    int m_run [4];
    int m_snap[4];

    always #5 clk = ~clk;

    slot_status_counter_bank uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .slot_done(slot_done), .a_frame(a_frame),
        .a_err(a_err), .b_frame(b_frame), .b_err(b_err), .cycle_end(cycle_end),
        .counts(counts)
    );

    // reference: does one channel satisfy a condition word (fields at bits 13:3)
    function automatic int ch_hit(int c, int fr, int er);
        int mask;
        mask = (c >> 10) & 15;
        if (((c >> 6) & 1) == 1 && (fr & 1) == 0)        return 0;
        if (((c >> 7) & 1) == 1 && ((fr >> 1) & 1) == 0) return 0;
        if (((c >> 8) & 1) == 1 && ((fr >> 2) & 1) == 1) return 0;
        if (((c >> 9) & 1) == 1 && ((fr >> 3) & 1) == 0) return 0;
        if (mask != 0 && (mask & er) == 0)                return 0;
        return 1;
    endfunction

    function automatic int inc_of(int c, int ha, int hb);
        case ((c >> 4) & 3)
            0:       return ha;
            1:       return hb;
            2:       return (ha | hb);
            default: return ha + hb;
        endcase
    endfunction

    function automatic int visible(int i);
        return (((m_cfg[i] >> 3) & 1) == 1) ? m_run[i] : m_snap[i];
    endfunction

    function automatic int model_rd();
        return m_cfg[m_sel] | (m_wm << 2) | m_sel;
    endfunction

    // cycle-by-cycle reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_wm = 0;
            for (int i = 0; i < 4; i++) begin
                m_cfg[i] = 0; m_run[i] = 0; m_snap[i] = 0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                int nv;
                nv = m_run[i];
                if (slot_done) begin
                    nv = nv + inc_of(m_cfg[i], ch_hit(m_cfg[i], int'(a_frame), int'(a_err)),
                                               ch_hit(m_cfg[i], int'(b_frame), int'(b_err)));
                    if (nv > 65535) nv = 65535;
                end
                if (cycle_end && ((m_cfg[i] >> 3) & 1) == 0) begin
                    m_snap[i] = nv;
                    m_run[i]  = 0;
                end else begin
                    m_run[i] = nv;
                end
            end
            if (host_wr) begin
                m_sel = int'(host_wdata) & 3;
                m_wm  = (int'(host_wdata) >> 2) & 1;
                if (m_wm == 0) m_cfg[m_sel] = int'(host_wdata) & 16'h3FF8;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        #2;
        chk("R3 control word vs model", {16'h0, host_rdata}, model_rd());
        for (int i = 0; i < 4; i++)
            chk("R12 counter vs model", {16'h0, counts[i*16 +: 16]}, visible(i));
    end

    task automatic wr(logic [15:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic slot(logic [3:0] af, logic [3:0] ae, logic [3:0] bf, logic [3:0] be, logic ce);
        @(negedge clk);
        slot_done = 1'b1; a_frame = af; a_err = ae; b_frame = bf; b_err = be; cycle_end = ce;
        @(negedge clk);
        slot_done = 1'b0; a_frame = '0; a_err = '0; b_frame = '0; b_err = '0; cycle_end = 1'b0;
    endtask

    task automatic cyc_end();
        @(negedge clk); cycle_end = 1'b1;
        @(negedge clk); cycle_end = 1'b0;
    endtask

    task automatic burst(int n);
        @(negedge clk); slot_done = 1'b1;
        repeat (n) @(negedge clk);
        slot_done = 1'b0;
    endtask

    function automatic logic [31:0] cnt(int i);
        return {16'h0, counts[i*16 +: 16]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset read word", {16'h0, host_rdata}, 0);
        chk("R11 reset counts", {31'h0, |counts}, 0);

        // R1: full writes, valid-only on all, modes A/B/any/sum, multi-cycle
        wr(16'h0048); wr(16'h0059); wr(16'h006A); wr(16'h007B);
        chk("R1 full write readback", {16'h0, host_rdata}, 32'h007B);
        // R2: select-only write with garbage fields
        wr(16'h3FF5);
        chk("R2 select-only keeps cfg1", {16'h0, host_rdata}, 32'h005D);
        wr(16'h0007);
        chk("R2 select-only keeps cfg3", {16'h0, host_rdata}, 32'h007F);

        // R6/R7: A only, B only, both
        slot(4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'h0, 4'h0, 4'h1, 4'h0, 1'b0);
        slot(4'h1, 4'h0, 4'h1, 4'h0, 1'b0);
        chk("R6 mode A", cnt(0), 2);
        chk("R6 mode B", cnt(1), 2);
        chk("R6 mode any", cnt(2), 3);
        chk("R7 mode sum", cnt(3), 4);

        // R4: all qualifiers on counter 0, each frame fails one
        wr(16'h03C8);
        slot(4'b1011, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'b1111, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'b1001, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'b0011, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'b1010, 4'h0, 4'h0, 4'h0, 1'b0);
        chk("R4 qualifiers", cnt(0), 3);

        // R5: mask syntax+conflict on counter 1, channel B
        wr(16'h2419);
        slot(4'h0, 4'h0, 4'h0, 4'b0000, 1'b0);
        slot(4'h0, 4'h0, 4'h0, 4'b0010, 1'b0);
        slot(4'h0, 4'h0, 4'h0, 4'b1000, 1'b0);
        slot(4'h0, 4'h0, 4'h0, 4'b0001, 1'b0);
        slot(4'h0, 4'b1000, 4'h0, 4'h0, 1'b0);
        chk("R5 error mask", cnt(1), 4);

        // R8: counter 2 single-cycle
        wr(16'h0062);
        chk("R8 published before strobe", cnt(2), 0);
        slot(4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
        chk("R8 no change before strobe", cnt(2), 0);
        cyc_end();
        chk("R8 publish at cycle end", cnt(2), 9);
        slot(4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
        slot(4'h1, 4'h0, 4'h0, 4'h0, 1'b1);
        chk("R8 coincident slot included", cnt(2), 2);
        cyc_end();
        chk("R8 empty cycle", cnt(2), 0);
        // R9: counter 3 multi-cycle ignores cycle end
        chk("R9 accumulates", cnt(3), 12);

        // R12: counter 3 configuration untouched by other writes
        wr(16'h0007);
        chk("R12 cfg3 independent", {16'h0, host_rdata}, 32'h007F);

        // R10: counter 3 sum mode, no restrictions, +2 per slot
        wr(16'h003B);
        burst(32761);
        chk("R10 below limit", cnt(3), 65534);
        slot(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 saturates", cnt(3), 65535);
        slot(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
        chk("R10 holds at max", cnt(3), 65535);
        cyc_end();
        chk("R9 cycle end no effect", cnt(3), 65535);

        // R11: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 reset read word", {16'h0, host_rdata}, 0);
        chk("R11 reset counts", {31'h0, |counts}, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R11 watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule